// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a single-clock synchronous memory whose data bus can carry one transfer on every clock, whatever the mix of reads and writes. Every command input is registered on the rising edge. The command inputs are the load strobe, the read/write level, the three chip selects, the address and the per-lane write strobes. A write's data is sampled two edges after its command. A read's data leaves a registered output two edges after its command. Because the two latencies match, a read may directly follow a write, or a write a read, with no idle slot between them.

A read that overlaps a write still in flight gets the newer bytes of that write, merged lane by lane. When the load strobe is high, the block continues the previous cycle type at the next address of a four-word wrapping group. A clock-enable input freezes the whole pipeline. An asynchronous output enable and a sleep input gate the output drivers.

The interface has no valid/ready handshake. Timing is fixed, and the clock enable is the only stall: while it is inactive, no input is sampled and no output changes. A host that must pause holds the clock enable inactive. It does not assert back-pressure.

Top module: `pipe_sram`

## Requirements
- R1: A loaded command selects the block only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0 at its capture edge. Otherwise it is a deselect, which writes nothing and produces no read data.
- R2: A write captured at edge k takes its data from `d_in` at edge k+2. Lane i is bits [8i+7:8i] and is written only if `lane_we_n[i]` was 0 at edge k.
- R3: A read captured at edge k presents the word on `q_out` after edge k+2. From then on `q_en` is 1 when `oe_n`=0 and `sleep`=0.
- R4: Reads and writes may follow one another on consecutive edges in any order, with no idle cycle.
- R5: A read returns the contents as left by every write captured before it, including a write captured on the immediately preceding edge.
- R6: With `load_n`=1, the previous cycle type repeats. The address keeps its upper bits and its two low bits increment modulo 4. The write strobes are sampled on every edge.
- R7: With `cke_n`=1 at an edge, that edge has no effect: nothing is captured or written, and `q_out` and `q_en` stay unchanged.
- R8: `oe_n`=1 forces `q_en` to 0 at once, without a clock edge.
- R9: While `sleep`=1, new commands and continuations become deselects and `q_en` is 0. Memory contents are kept.
- R10: During reset (`rst_n`=0 at an edge), the pipeline empties to deselects and `q_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| load_n | input | 1 | Low: load a new command; high: continue |
| rd_wr_n | input | 1 | High read, low write |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| lane_we_n | input | NLANES | Per-lane write strobes, active low |
| addr | input | AW | Word address |
| d_in | input | NLANES*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Snooze request |
| q_out | output | NLANES*8 | Registered read data |
| q_en | output | 1 | Output driver enable (0 = high impedance) |

## Verification
A wrong cycle type or address in the capture stage shows up as a wrong word on `q_out`. For a read, this happens two enabled edges after the bad capture. For a write, the error appears only at the next read of the damaged word. A missing or misaligned forwarding path returns the older word. This is only visible when a read follows a write to the same address on the next edge, so the bench crowds its addresses into one small group. Errors in the clock-enable or sleep gating appear as `q_en` or `q_out` changing on an edge that should have been frozen or blocked.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pipe_sram_cmd.sv
module pipe_sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic              chip_sel,
  input  logic              sleep,
  input  logic [AW-1:0]     addr,
  input  logic [NLANES-1:0] lane_we_n,
  output op_e               op_q,
  output logic [AW-1:0]     addr_q,
  output logic [NLANES-1:0] lane_q
);
  op_e           op_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    if (!load_n) begin
      addr_d = addr;
      if (sleep || !chip_sel) op_d = OP_IDLE;
      else                    op_d = rd_wr_n ? OP_RD : OP_WR;
    end else begin
      addr_d      = addr_q;
      addr_d[1:0] = addr_q[1:0] + 2'd1;
      op_d        = sleep ? OP_IDLE : op_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      lane_q <= '0;
    end else if (en) begin
      op_q   <= op_d;
      addr_q <= addr_d;
      lane_q <= ~lane_we_n;
    end
  end
endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int AW = 6,
  parameter int NLANES = 4,
  parameter int LANE_W = 8,
  localparam int DW = NLANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NLANES-1:0] wr_lane,
  input  logic [DW-1:0]     wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
    end

    a_r2_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lane[i]) |=>
        mem[$past(wr_addr)][i*LANE_W +: LANE_W] == $past(wr_data[i*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/pipe_sram_fwd.sv
module pipe_sram_fwd #(
  parameter int NLANES = 4,
  parameter int LANE_W = 8,
  localparam int DW = NLANES * LANE_W
) (
  input  logic [DW-1:0]     raw,
  input  logic              hit,
  input  logic [NLANES-1:0] hit_lane,
  input  logic [DW-1:0]     hit_data,
  output logic [DW-1:0]     merged
);
  for (genvar i = 0; i < NLANES; i++) begin : g_mux
    assign merged[i*LANE_W +: LANE_W] = (hit && hit_lane[i]) ?
      hit_data[i*LANE_W +: LANE_W] : raw[i*LANE_W +: LANE_W];
  end

  always_comb begin
    if (hit === 1'b1 && (&hit_lane) === 1'b1)
      a_r5_full_hit: assert (merged == hit_data);
    if (hit === 1'b0)
      a_r5_no_hit: assert (merged == raw);
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NLANES = 4,
  localparam int LANE_W = 8,
  localparam int DW = NLANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic [NLANES-1:0] lane_we_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     d_in,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DW-1:0]     q_out,
  output logic              q_en
);
  logic              en;
  logic              chip_sel;
  op_e               op1, op2;
  logic [AW-1:0]     addr1, addr2;
  logic [NLANES-1:0] lane1, lane2;
  logic [DW-1:0]     raw;
  logic [DW-1:0]     merged;
  logic              hit_q;
  logic [NLANES-1:0] hit_lane_q;
  logic [DW-1:0]     hit_data_q;
  logic              q_valid;

  assign en       = !cke_n;
  assign chip_sel = !sel0_n && sel1 && !sel2_n;

  pipe_sram_cmd #(.AW(AW), .NLANES(NLANES)) cmd_i (
    .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n), .rd_wr_n(rd_wr_n),
    .chip_sel(chip_sel), .sleep(sleep), .addr(addr), .lane_we_n(lane_we_n),
    .op_q(op1), .addr_q(addr1), .lane_q(lane1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op2   <= OP_IDLE;
      addr2 <= '0;
      lane2 <= '0;
    end else if (en) begin
      op2   <= op1;
      addr2 <= addr1;
      lane2 <= lane1;
    end
  end

  pipe_sram_array #(.AW(AW), .NLANES(NLANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .rst_n(rst_n),
    .rd_en(en && op1 == OP_RD), .rd_addr(addr1), .rd_data(raw),
    .wr_en(en && op2 == OP_WR), .wr_addr(addr2), .wr_lane(lane2), .wr_data(d_in)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q      <= 1'b0;
      hit_lane_q <= '0;
      hit_data_q <= '0;
    end else if (en) begin
      hit_q      <= (op1 == OP_RD) && (op2 == OP_WR) && (addr1 == addr2);
      hit_lane_q <= lane2;
      hit_data_q <= d_in;
    end
  end

  pipe_sram_fwd #(.NLANES(NLANES), .LANE_W(LANE_W)) fwd_i (
    .raw(raw), .hit(hit_q), .hit_lane(hit_lane_q), .hit_data(hit_data_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_out   <= '0;
    end else if (en) begin
      q_valid <= (op2 == OP_RD);
      if (op2 == OP_RD) q_out <= merged;
    end
  end

  assign q_en = q_valid && !oe_n && !sleep;

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(q_out) && $stable(q_valid) && $stable(op1) && $stable(addr1)));
  a_r1_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && !chip_sel) |=> op1 == OP_IDLE);
  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && sleep) |=> op1 == OP_IDLE);
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && load_n) |=> (addr1[1:0] == $past(addr1[1:0]) + 2'd1));
  a_r3_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && op2 == OP_RD) |=> q_valid);
endmodule

// File: tb/pipe_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = NL * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cke_n = 1'b0, load_n = 1'b0, rd_wr_n = 1'b1;
  logic sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic [NL-1:0] lane_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] q_out;
  logic q_en;

  always #10 clk = ~clk;

  pipe_sram #(.AW(AW), .NLANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n), .rd_wr_n(rd_wr_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .lane_we_n(lane_we_n),
    .addr(addr), .d_in(d_in), .oe_n(oe_n), .sleep(sleep), .q_out(q_out), .q_en(q_en)
  );

  int vectors = 0;
  int errors = 0;
  string cur = "R10";

  // Reference model: ops queue, memory image, output state.
  typedef struct { int op; int a; logic [NL-1:0] be; } mop_t;  // op 0 idle, 1 read, 2 write
  mop_t pq[$];
  mop_t ex, nw;
  int prev_op = 0;
  int prev_a = 0;
  logic [DW-1:0] mm [64];
  logic m_qv = 1'b0;
  logic [DW-1:0] m_q = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete();
      nw.op = 0; nw.a = 0; nw.be = '0;
      pq.push_back(nw); pq.push_back(nw);
      prev_op = 0; prev_a = 0; m_qv = 1'b0; m_q = '0;
    end else if (!cke_n) begin
      ex = pq.pop_front();
      if (ex.op == 2)
        for (int i = 0; i < NL; i++)
          if (ex.be[i]) mm[ex.a][i*8 +: 8] = d_in[i*8 +: 8];
      if (ex.op == 1) begin m_q = mm[ex.a]; m_qv = 1'b1; end
      else m_qv = 1'b0;
      if (!load_n) begin
        nw.a = int'(addr);
        if (sleep || !(!sel0_n && sel1 && !sel2_n)) nw.op = 0;
        else nw.op = rd_wr_n ? 1 : 2;
      end else begin
        nw.a = (prev_a & ~3) | ((prev_a + 1) & 3);
        nw.op = sleep ? 0 : prev_op;
      end
      nw.be = ~lane_we_n;
      pq.push_back(nw);
      prev_op = nw.op; prev_a = nw.a;
    end
  end

  always @(negedge clk) begin
    logic exp_en;
    exp_en = m_qv && !oe_n && !sleep;
    vectors++;
    if (!rst_n) begin
      if (q_en !== 1'b0) begin
        errors++;
        $display("FAIL R10 reset q_en=%b expected 0", q_en);
      end
    end else if (q_en !== exp_en) begin
      errors++;
      $display("FAIL %s q_en=%b expected %b", cur, q_en, exp_en);
    end else if (exp_en && q_out !== m_q) begin
      errors++;
      $display("FAIL %s q_out=%h expected %h", cur, q_out, m_q);
    end
  end

  task automatic setin(bit ld, bit rd, bit sel, logic [NL-1:0] wen, int a);
    @(posedge clk); #5;
    load_n = ld; rd_wr_n = rd; addr = AW'(a); lane_we_n = wen;
    sel0_n = !sel; sel1 = sel; sel2_n = !sel;
    d_in = DW'($urandom);
  endtask

  // percentages: load, deselect, stall, oe off, sleep
  task automatic rnd(int n, int p_ld, int p_ds, int p_ck, int p_oe, int p_sl, int amask);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #5;
      load_n  = !(($urandom % 100) < p_ld);
      rd_wr_n = $urandom % 2;
      addr    = AW'($urandom & amask);
      lane_we_n = NL'($urandom);
      sel0_n  = (($urandom % 100) < p_ds);
      sel1    = !(($urandom % 100) < p_ds);
      sel2_n  = (($urandom % 100) < p_ds);
      cke_n   = (($urandom % 100) < p_ck);
      oe_n    = (($urandom % 100) < p_oe);
      sleep   = (($urandom % 100) < p_sl);
      d_in    = DW'($urandom);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    cur = "R2";
    for (int i = 0; i < 64; i++) setin(1'b0, 1'b0, 1'b1, '0, i);
    cur = "R3";
    for (int i = 0; i < 64; i++) setin(1'b0, 1'b1, 1'b1, '0, i);
    cur = "R4";
    for (int i = 0; i < 64; i++) setin(1'b0, i[0], 1'b1, NL'($urandom), i % 8);
    cur = "R5";
    for (int i = 0; i < 40; i++) begin
      setin(1'b0, 1'b0, 1'b1, NL'($urandom), i % 4);
      setin(1'b0, 1'b1, 1'b1, '1, i % 4);
    end
    cur = "R1"; rnd(300, 100, 30, 0, 0, 0, 7);
    cur = "R6"; rnd(300, 30, 5, 0, 0, 0, 7);
    cur = "R7"; rnd(300, 70, 5, 30, 0, 0, 7);
    cur = "R8"; rnd(300, 70, 5, 10, 30, 0, 7);
    cur = "R9"; rnd(300, 70, 5, 10, 5, 30, 7);
    cke_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    cur = "R9";  // contents kept after sleep
    for (int i = 0; i < 64; i++) setin(1'b0, 1'b1, 1'b1, '1, i);
    setin(1'b0, 1'b1, 1'b0, '1, 0);
    repeat (4) @(posedge clk);
    cur = "R10";
    #5 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #15;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule